// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This unit holds a small set of data watchpoints and compares every access on a memory access port against them. Each watchpoint has an address word and a control word. The control word gives an address mask field and two direction enables, one for loads and one for stores. When an access falls inside the watched region of an enabled watchpoint and its direction is enabled, the unit raises a hit and gives the watchpoint number. The hit is combinational, so it is present in the same cycle as the access and before the access completes. The surrounding core uses it to stop the access and raise its debug exception; this unit does not deliver that exception.

The mask is always a run of ones from the top bit downward. The control field supplies only the low mask bits, and every bit above the field counts as one. If the resulting mask is not a contiguous run of high ones, it is cut at its first zero bit (counting from the top), and all bits below that zero are cleared. As a result, each watchpoint covers one naturally aligned power-of-two byte region. A configuration port writes the address or the control word of one watchpoint per cycle. The normalised mask and the region base are worked out at write time.

Top module: `wp_watch_unit`

## Requirements
- R1: After reset every watchpoint is inactive, and no access gives a hit until a control word has been written.
- R2: Bit 8 of the control word enables hits on reads (`acc_write`=0). Bit 9 enables hits on writes (`acc_write`=1). An access whose direction is not enabled does not hit.
- R3: A watchpoint whose control word has both bit 8 and bit 9 clear never hits, whatever its address and mask.
- R4: The mask field is the low `MASK_W` bits (bits 5:0 by default) of the control word. All mask bits above the field count as one, so a field of zero watches a naturally aligned 64-byte region.
- R5: When the mask is a contiguous run of high ones, an access hits if (access address AND mask) equals (stored address AND mask). The region length is the inverted mask plus one.
- R6: A mask that is not contiguous is replaced by ones from bit 31 down to, but not including, its highest zero bit, with zeros below. For example, field 0x35 watches a 16-byte region.
- R7: The hit and its index depend combinationally on the access inputs and appear in the same cycle as the access.
- R8: When several watchpoints hit the same access, `dbg_idx` reports the lowest-numbered one.
- R9: A configuration write (`cfg_sel`=0 writes the address word, 1 writes the control word) affects accesses from the following cycle on. An address write rebases the region using the current mask.
- R10: No hit is reported while `acc_valid` is low, and `dbg_idx` is zero whenever `dbg_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: address word, 1: control word |
| cfg_idx | input | IDX_W | Watchpoint number being written |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present on the port this cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Access byte address |
| dbg_hit | output | 1 | Access matches an enabled watchpoint |
| dbg_idx | output | IDX_W | Lowest matching watchpoint number |

## Verification
A hit is due in the same cycle as the access that causes it, with no register in the path. The bench therefore drives each access 1 ns after a rising edge and compares the outputs 4 ns later, well before the next edge. A configuration write changes what is due only from the next cycle. For this reason the reference model applies a write at the rising edge that ends the write cycle, and the access driven in the write cycle itself is still judged against the old settings. Directed vectors also carry a literal expected index, worked out by hand from the requirements, in addition to the model's prediction.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int WP_AW = 32;

    typedef logic [WP_AW-1:0] wp_word_t;

    // Per-watchpoint register set: raw address, normalised mask and the
    // pre-masked region base, plus the two direction enables.
    typedef struct packed {
        wp_word_t addr;
        wp_word_t mask;
        wp_word_t base;
        logic     ld_en;
        logic     st_en;
    } wp_slot_t;

    typedef enum logic {
        CFG_ADDR = 1'b0,
        CFG_CTRL = 1'b1
    } wp_cfg_e;

endpackage

// File: rtl/wp_mask_norm.sv
// Builds the effective mask from the control field: bits above the field
// are ones, then every bit below the highest zero is forced to zero.
module wp_mask_norm #(
    parameter int AW     = 32,
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] field,
    output logic [AW-1:0]     mask
);
    localparam int HI_W = AW - MASK_W;

    logic [AW-1:0] raw;
    logic [AW-1:0] keep;

    assign raw = {{HI_W{1'b1}}, field};

    // Prefix AND from the top bit: a bit survives only if every bit above
    // it is also one.
    assign keep[AW-1] = raw[AW-1];
    for (genvar b = AW - 2; b >= 0; b--) begin : g_prefix
        assign keep[b] = keep[b+1] & raw[b];
    end

    assign mask = keep;

endmodule

// File: rtl/wp_slot.sv
// One watchpoint: configuration registers plus its match logic.
module wp_slot
    import wp_pkg::*;
#(
    parameter int MASK_W = 6,
    parameter int LD_POS = 8,
    parameter int ST_POS = 9
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_sel,
    input  wp_word_t wr_data,
    input  logic     acc_valid,
    input  logic     acc_write,
    input  wp_word_t acc_addr,
    output logic     hit
);
    wp_slot_t s_d, s_q;
    wp_word_t new_mask;
    logic     dir_ok;

    wp_mask_norm #(
        .AW     (WP_AW),
        .MASK_W (MASK_W)
    ) u_norm (
        .field (wr_data[MASK_W-1:0]),
        .mask  (new_mask)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en && wr_sel == CFG_CTRL) begin
            s_d.mask  = new_mask;
            s_d.base  = s_q.addr & new_mask;
            s_d.ld_en = wr_data[LD_POS];
            s_d.st_en = wr_data[ST_POS];
        end else if (wr_en) begin
            s_d.addr = wr_data;
            s_d.base = wr_data & s_q.mask;
        end

        dir_ok = acc_write ? s_q.st_en : s_q.ld_en;
        hit    = acc_valid && dir_ok && ((acc_addr & s_q.mask) == s_q.base);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.addr  <= '0;
            s_q.mask  <= '1;
            s_q.base  <= '0;
            s_q.ld_en <= 1'b0;
            s_q.st_en <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/wp_prio.sv
// Lowest-index-wins encoder over the per-watchpoint hits.
module wp_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wp_watch_unit.sv
module wp_watch_unit
    import wp_pkg::*;
#(
    parameter int NWP    = 4,
    parameter int MASK_W = 6,
    parameter int LD_POS = 8,
    parameter int ST_POS = 9,
    localparam int IDX_W = (NWP > 1) ? $clog2(NWP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_wdata,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [31:0]      acc_addr,
    output logic             dbg_hit,
    output logic [IDX_W-1:0] dbg_idx
);
    logic [NWP-1:0] slot_hit;

    for (genvar g = 0; g < NWP; g++) begin : g_slot
        logic wr_here;
        assign wr_here = cfg_we && (cfg_idx == IDX_W'(g));

        wp_slot #(
            .MASK_W (MASK_W),
            .LD_POS (LD_POS),
            .ST_POS (ST_POS)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_here),
            .wr_sel    (cfg_sel),
            .wr_data   (cfg_wdata),
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .acc_addr  (acc_addr),
            .hit       (slot_hit[g])
        );
    end

    wp_prio #(
        .N     (NWP),
        .IDX_W (IDX_W)
    ) u_prio (
        .req (slot_hit),
        .any (dbg_hit),
        .idx (dbg_idx)
    );

endmodule

// File: rtl/wp_watch_unit_chk.sv
module wp_watch_unit_chk #(
    parameter int NWP   = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [31:0]      acc_addr,
    input logic [NWP-1:0]   slot_hit,
    input logic             dbg_hit,
    input logic [IDX_W-1:0] dbg_idx
);
    // R1: nothing is armed in the first cycle out of reset
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dbg_hit);

    // R10: no access, no hit
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !dbg_hit);

    // R10: index parked at zero without a hit
    p_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_hit |-> dbg_idx == '0);

    // R8: the reported slot hits and no lower slot does
    p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit |-> (slot_hit[dbg_idx] &&
                     ((slot_hit & ((NWP'(1) << dbg_idx) - NWP'(1))) == '0)));

    // R9: with no write in the previous cycle and an unchanged access,
    // the result cannot move
    p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(acc_valid) && $stable(acc_write) &&
         $stable(acc_addr)) |-> ($stable(dbg_hit) && $stable(dbg_idx)));

endmodule

bind wp_watch_unit wp_watch_unit_chk #(
    .NWP   (NWP),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .slot_hit  (slot_hit),
    .dbg_hit   (dbg_hit),
    .dbg_idx   (dbg_idx)
);

// File: tb/wp_watch_unit_tb.sv
module wp_watch_unit_tb;
    localparam int NWP    = 4;
    localparam int MASK_W = 6;
    localparam int LD_POS = 8;
    localparam int ST_POS = 9;
    localparam int IDX_W  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             acc_valid = 1'b0;
    logic             acc_write = 1'b0;
    logic [31:0]      acc_addr = '0;
    logic             dbg_hit;
    logic [IDX_W-1:0] dbg_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // reference state
    logic [31:0] m_addr [NWP];
    logic [31:0] m_ctrl [NWP];
    bit          p_we = 1'b0;
    bit          p_sel = 1'b0;
    int          p_idx = 0;
    logic [31:0] p_data = '0;

    wp_watch_unit #(
        .NWP    (NWP),
        .MASK_W (MASK_W),
        .LD_POS (LD_POS),
        .ST_POS (ST_POS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .dbg_hit   (dbg_hit),
        .dbg_idx   (dbg_idx)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] eff_mask(input logic [31:0] ctrl);
        logic [31:0] m;
        int          ones;
        m    = ~((32'd1 << MASK_W) - 32'd1) | (ctrl & ((32'd1 << MASK_W) - 32'd1));
        ones = 0;
        while (ones < 32 && m[31 - ones]) ones++;
        if (ones == 32) return 32'hFFFF_FFFF;
        return ~(32'hFFFF_FFFF >> ones);
    endfunction

    // want: -1 no hit, >=0 expected index, -2 model only
    task automatic cyc(input bit we, input bit sel, input int idx,
                       input logic [31:0] data, input bit av, input bit aw,
                       input logic [31:0] aa, input int want, input string tag);
        bit          e_hit;
        int          e_idx;
        logic [31:0] mk;
        bit          en;
        @(posedge clk);
        if (p_we) begin
            if (p_sel) m_ctrl[p_idx] = p_data;
            else       m_addr[p_idx] = p_data;
        end
        #1;
        cfg_we = we; cfg_sel = sel; cfg_idx = IDX_W'(idx); cfg_wdata = data;
        acc_valid = av; acc_write = aw; acc_addr = aa;
        p_we = we; p_sel = sel; p_idx = idx; p_data = data;
        #4;
        e_hit = 1'b0;
        e_idx = 0;
        for (int i = NWP - 1; i >= 0; i--) begin
            mk = eff_mask(m_ctrl[i]);
            en = aw ? m_ctrl[i][ST_POS] : m_ctrl[i][LD_POS];
            if (av && en && ((aa & mk) == (m_addr[i] & mk))) begin
                e_hit = 1'b1;
                e_idx = i;
            end
        end
        n_checks++;
        if (dbg_hit !== e_hit || int'(dbg_idx) != e_idx || $isunknown(dbg_idx)) begin
            n_fails++;
            $display("FAIL %s model: hit=%0d idx=%0d expected hit=%0d idx=%0d",
                     tag, dbg_hit, dbg_idx, e_hit, e_idx);
        end
        if (want != -2) begin
            n_checks++;
            if ((want == -1 && dbg_hit !== 1'b0) ||
                (want >= 0 && (dbg_hit !== 1'b1 || int'(dbg_idx) != want))) begin
                n_fails++;
                $display("FAIL %s literal: hit=%0d idx=%0d expected %0d",
                         tag, dbg_hit, dbg_idx, want);
            end
        end
    endtask

    task automatic acc(input bit aw, input logic [31:0] aa, input int want,
                       input string tag);
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b1, aw, aa, want, tag);
    endtask

    task automatic wr(input bit sel, input int idx, input logic [31:0] d);
        cyc(1'b1, sel, idx, d, 1'b0, 1'b0, 32'h0, -1, "R10");
    endtask

    initial begin
        for (int i = 0; i < NWP; i++) begin
            m_addr[i] = '0;
            m_ctrl[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        acc(1'b0, 32'h0, -1, "R1");
        acc(1'b1, 32'h0, -1, "R1");
        cyc(1'b1, 1'b0, 0, 32'h1000, 1'b1, 1'b0, 32'h1000, -1, "R1");
        // control written while an access sits in the same cycle
        cyc(1'b1, 1'b1, 0, 32'h13C, 1'b1, 1'b0, 32'h1000, -1, "R9");
        acc(1'b0, 32'h1002, 0, "R2");
        acc(1'b1, 32'h1002, -1, "R2");
        acc(1'b0, 32'h1003, 0, "R5");
        acc(1'b0, 32'h1004, -1, "R5");
        acc(1'b0, 32'h0FFF, -1, "R5");
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0, 32'h1000, -1, "R10");

        wr(1'b0, 1, 32'h2003);
        wr(1'b1, 1, 32'h23F);
        acc(1'b1, 32'h2003, 1, "R2");
        acc(1'b0, 32'h2003, -1, "R2");
        acc(1'b1, 32'h2002, -1, "R5");

        wr(1'b0, 2, 32'h3025);
        wr(1'b1, 2, 32'h000);
        acc(1'b0, 32'h3025, -1, "R3");
        acc(1'b1, 32'h3025, -1, "R3");
        wr(1'b1, 2, 32'h300);
        acc(1'b0, 32'h3000, 2, "R4");
        acc(1'b1, 32'h303F, 2, "R4");
        acc(1'b0, 32'h3040, -1, "R4");
        acc(1'b1, 32'h2FFF, -1, "R4");

        wr(1'b0, 3, 32'h4000);
        wr(1'b1, 3, 32'h135);
        acc(1'b0, 32'h4004, 3, "R6");
        acc(1'b0, 32'h400F, 3, "R6");
        acc(1'b0, 32'h4010, -1, "R6");

        wr(1'b0, 1, 32'h1000);
        wr(1'b1, 1, 32'h33C);
        acc(1'b0, 32'h1001, 0, "R8");
        acc(1'b1, 32'h1001, 1, "R8");

        cyc(1'b1, 1'b0, 0, 32'h5000, 1'b1, 1'b0, 32'h1001, 0, "R9");
        acc(1'b0, 32'h1001, 1, "R9");
        acc(1'b0, 32'h5003, 0, "R9");

        for (int k = 0; k < 400; k++) begin
            bit          w;
            logic [31:0] d;
            w = ($urandom % 8) == 0;
            d = w ? (($urandom % 2) ? ($urandom & 32'h3FF) : ($urandom & 32'h5FFF))
                  : 32'h0;
            cyc(w, $urandom % 2, $urandom % NWP, d, ($urandom % 4) != 0,
                $urandom % 2, $urandom & 32'h5FFF, -2, "R7");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: hit=%0d idx=%0d expected run to end", dbg_hit, dbg_idx);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule